// File: doc/BRIEF.md
# Programmable Interrupt Countdown Timer

A 16-bit down counter that raises a periodic, level-sensitive interrupt. Software talks to it over a single-cycle register port. The port has three halfword registers:

- a control/status register at byte offset 0;
- a modulus register at offset 2;
- a read-only live count register at offset 4.

The count advances once per prescaled tick. A tick comes every 2^(p+1) clock cycles, where p is a four-bit prescale field. The timer runs in one of two modes:

- **Reload mode:** the count restarts from the modulus value after it reaches the end of its period.
- **Free-running mode:** the count restarts from 0xFFFF.

Each wrap sets an interrupt flag. The interrupt output follows the flag when the interrupt enable bit is set.

Writes to the control register fall into two classes:

- **Light write:** changes only the interrupt enable bit and/or clears the flag. The running count and the tick phase are left alone.
- **Heavy write:** changes any other stored bit. The count is reloaded from the new limit and the tick phase restarts.

A modulus write always clears the flag. It loads the count at once only when the overwrite bit is set; otherwise the new modulus is used at the next wrap.

Top module: `countdown_irq_timer`

## Requirements
- R1: After reset, control reads 0x0000, modulus reads 0xFFFF, count reads 0xFFFF, read data is 0 and the interrupt output is low.
- R2: The control register holds run enable (bit 0), reload mode (bit 1), interrupt flag (bit 2), interrupt enable (bit 3), overwrite (bit 4), two stored-only bits 5 and 6 with no effect on counting, and prescale p in bits 11:8. All other bits read as 0.
- R3: While enabled, the count decrements once every 2^(p+1) clock cycles. The first decrement comes that many cycles after the heavy write that started the timer.
- R4: In reload mode, a tick that finds the count at 1 or 0 loads the modulus value, so the period is the modulus value in ticks.
- R5: In free-running mode, the count reloads from 0xFFFF instead.
- R6: The tick that reloads the count sets the interrupt flag. The interrupt output is high exactly when the flag and interrupt enable are both 1.
- R7: Writing control with bit 2 set clears the flag. Writing bit 2 as 0 leaves the flag unchanged.
- R8: A control write that differs from the stored value only in interrupt enable (and/or bit 2) does not disturb the count or the tick phase. Any other change reloads the count from the new limit and restarts the tick phase.
- R9: A modulus write clears the flag. With overwrite set, it loads the count at once. With overwrite clear, the count is untouched and the new modulus applies at the next reload.
- R10: The count register reads the live count and ignores writes. Offsets other than 0, 2 and 4 read 0 and ignore writes.
- R11: Read data is registered: it shows the register selected by the address present at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_o | output | 1 | Level interrupt request |

## Verification
The checker assumes each write strobe lasts one cycle with stable address and data. It also assumes a flag clear and a wrap landing on the same edge are resolved in favour of the wrap; its clear properties exclude that edge. The bench drives every access half a cycle away from the edge, one register operation per cycle. It times its flag clears so that none meets a tick, which keeps both assumptions true and makes every expected count an exact function of elapsed cycles, prescale and modulus.

// File: rtl/pit_pkg.sv
package pit_pkg;
   localparam int OFF_CTL = 0;
   localparam int OFF_MOD = 2;
   localparam int OFF_CNT = 4;
   localparam int PRE_LSB = 8;

   typedef struct packed {
      logic doze;
      logic dbg;
      logic ovw;
      logic ie;
      logic flag;
      logic rld;
      logic en;
   } ctl_bits_t;

   localparam int CTL_BITS = $bits(ctl_bits_t);

   typedef enum logic [1:0] {
      SEL_CTL,
      SEL_MOD,
      SEL_CNT,
      SEL_NONE
   } reg_sel_e;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
   parameter int PRE_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [PRE_W-1:0] pre,
   output logic             tick
);
   localparam int DIV_W = (1 << PRE_W) + 1;

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] last;

   assign last = (DIV_W'(2) << pre) - DIV_W'(1);
   assign tick = run && !restart && (div_q == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
      end else if (restart) begin
         div_q <= '0;
      end else if (run) begin
         div_q <= (div_q == last) ? '0 : div_q + DIV_W'(1);
      end
   end
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   logic at_end;

   assign at_end = (cnt <= CNT_W'(1));
   assign wrap   = tick && !load && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '1;
      end else if (load) begin
         cnt <= load_val;
      end else if (tick) begin
         cnt <= at_end ? limit : cnt - CNT_W'(1);
      end
   end
endmodule

// File: rtl/pit_regs.sv
module pit_regs
   import pit_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int PRE_W  = 4,
   parameter int DATA_W = 16,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              wrap,
   input  logic [CNT_W-1:0]  cnt,
   output ctl_bits_t         ctl_q,
   output logic [PRE_W-1:0]  pre_q,
   output logic [CNT_W-1:0]  mod_q,
   output logic              restart,
   output logic              load,
   output logic [CNT_W-1:0]  load_val,
   output logic [CNT_W-1:0]  limit,
   output logic [DATA_W-1:0] bus_rdata
);
   reg_sel_e         sel;
   ctl_bits_t        w_bits;
   logic [PRE_W-1:0] w_pre;
   logic [CNT_W-1:0] w_val;
   logic             wr_ctl;
   logic             wr_mod;
   logic             changed;
   logic             flag_clr;
   logic [DATA_W-1:0] ctl_view;
   logic [DATA_W-1:0] rd_next;

   always_comb begin
      if (bus_addr == ADDR_W'(OFF_CTL))      sel = SEL_CTL;
      else if (bus_addr == ADDR_W'(OFF_MOD)) sel = SEL_MOD;
      else if (bus_addr == ADDR_W'(OFF_CNT)) sel = SEL_CNT;
      else                                   sel = SEL_NONE;
   end

   assign w_bits = ctl_bits_t'(bus_wdata[CTL_BITS-1:0]);
   assign w_pre  = bus_wdata[PRE_LSB +: PRE_W];
   assign w_val  = bus_wdata[CNT_W-1:0];
   assign wr_ctl = bus_wr && (sel == SEL_CTL);
   assign wr_mod = bus_wr && (sel == SEL_MOD);

   assign changed = (w_bits.en   != ctl_q.en)   ||
                    (w_bits.rld  != ctl_q.rld)  ||
                    (w_bits.ovw  != ctl_q.ovw)  ||
                    (w_bits.dbg  != ctl_q.dbg)  ||
                    (w_bits.doze != ctl_q.doze) ||
                    (w_pre       != pre_q);

   assign restart  = wr_ctl && changed;
   assign flag_clr = (wr_ctl && w_bits.flag) || wr_mod;
   assign load     = restart || (wr_mod && ctl_q.ovw);
   assign load_val = restart ? (w_bits.rld ? mod_q : '1) : w_val;
   assign limit    = ctl_q.rld ? mod_q : '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         pre_q <= '0;
         mod_q <= '1;
      end else begin
         if (wr_ctl) begin
            ctl_q.en   <= w_bits.en;
            ctl_q.rld  <= w_bits.rld;
            ctl_q.ie   <= w_bits.ie;
            ctl_q.ovw  <= w_bits.ovw;
            ctl_q.dbg  <= w_bits.dbg;
            ctl_q.doze <= w_bits.doze;
            pre_q      <= w_pre;
         end
         if (wrap)          ctl_q.flag <= 1'b1;
         else if (flag_clr) ctl_q.flag <= 1'b0;
         if (wr_mod) mod_q <= w_val;
      end
   end

   always_comb begin
      ctl_view = '0;
      ctl_view[CTL_BITS-1:0]    = ctl_q;
      ctl_view[PRE_LSB +: PRE_W] = pre_q;
   end

   always_comb begin
      unique case (sel)
         SEL_CTL: rd_next = ctl_view;
         SEL_MOD: rd_next = DATA_W'(mod_q);
         SEL_CNT: rd_next = DATA_W'(cnt);
         default: rd_next = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_rdata <= '0;
      else        bus_rdata <= rd_next;
   end
endmodule

// File: rtl/countdown_irq_timer.sv
module countdown_irq_timer
   import pit_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int PRE_W  = 4,
   parameter int DATA_W = 16,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o
);
   generate
      if (PRE_W < 1 || PRE_W > 5) begin : g_bad_pre
         $error("PRE_W must lie in 1..5");
      end
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("CNT_W must lie in 2..DATA_W");
      end
      if (PRE_LSB + PRE_W > DATA_W) begin : g_bad_data
         $error("DATA_W too narrow for the prescale field");
      end
      if ((1 << ADDR_W) <= OFF_CNT) begin : g_bad_addr
         $error("ADDR_W too narrow to reach the count register");
      end
   endgenerate

   ctl_bits_t        ctl_q;
   logic [PRE_W-1:0] pre_q;
   logic [CNT_W-1:0] mod_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_val;
   logic [CNT_W-1:0] limit;
   logic             restart;
   logic             load;
   logic             tick;
   logic             wrap;

   pit_regs #(
      .CNT_W(CNT_W), .PRE_W(PRE_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .wrap(wrap), .cnt(cnt_q),
      .ctl_q(ctl_q), .pre_q(pre_q), .mod_q(mod_q),
      .restart(restart), .load(load), .load_val(load_val), .limit(limit),
      .bus_rdata(bus_rdata)
   );

   pit_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n),
      .run(ctl_q.en), .restart(restart), .pre(pre_q),
      .tick(tick)
   );

   pit_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .tick(tick), .load(load), .load_val(load_val), .limit(limit),
      .cnt(cnt_q), .wrap(wrap)
   );

   assign irq_o = ctl_q.flag & ctl_q.ie;
endmodule

// File: rtl/countdown_irq_timer_chk.sv
module countdown_irq_timer_chk #(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 16,
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              irq_o,
   input logic              en,
   input logic              ovw,
   input logic              flag,
   input logic              tick,
   input logic              wrap,
   input logic [CNT_W-1:0]  cnt
);
   logic wr_ctl, wr_mod, wr_cnt;
   assign wr_ctl = bus_wr && (bus_addr == ADDR_W'(0));
   assign wr_mod = bus_wr && (bus_addr == ADDR_W'(2));
   assign wr_cnt = bus_wr && (bus_addr == ADDR_W'(4));

   // R6: flag only rises after a wrap of the counter
   a_r6_flag_from_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(wrap));

   // R6: every wrap leaves the flag set
   a_r6_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> flag);

   // R6: interrupt never asserted without a pending flag
   a_r6_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> flag);

   // R7: write-one-to-clear of the flag
   a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && bus_wdata[2] && !wrap) |=> !flag);

   // R9: modulus write clears the flag
   a_r9_mod_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mod && !wrap) |=> !flag);

   // R9: overwrite loads the count immediately
   a_r9_ovw_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mod && ovw) |=> (cnt == $past(bus_wdata[CNT_W-1:0])));

   // R10: writes to the count register leave it alone
   a_r10_cnt_ro: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cnt && !tick) |=> $stable(cnt));

   // R3: stopped timer with no writes holds its count
   a_r3_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !bus_wr) |=> $stable(cnt));

   // R4: ordinary tick steps down by one
   a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (cnt > CNT_W'(1)) && !bus_wr) |=> (cnt == $past(cnt) - CNT_W'(1)));
endmodule

bind countdown_irq_timer countdown_irq_timer_chk #(
   .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
   .irq_o(irq_o), .en(ctl_q.en), .ovw(ctl_q.ovw), .flag(ctl_q.flag),
   .tick(tick), .wrap(wrap), .cnt(cnt_q)
);

// File: tb/tb_countdown_irq_timer.sv
module tb_countdown_irq_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   countdown_irq_timer dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   always #4 clk = ~clk;

   task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h t=%0t", req, got, exp, $time);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      bus_addr = a;
      @(negedge clk);
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog got=hang exp=finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      repeat (3) @(negedge clk);
      // R1 reset values
      chk("R1 rdata", bus_rdata, 16'h0000);
      chk("R1 irq", {15'd0, irq_o}, 16'd0);
      rst_n = 1'b1;
      rd(3'd0, v); chk("R1 ctl", v, 16'h0000);
      rd(3'd2, v); chk("R1 mod", v, 16'hFFFF);
      rd(3'd4, v); chk("R1 cnt", v, 16'hFFFF);

      // R2 layout and unused bits
      wr(3'd0, 16'hFF72);
      rd(3'd0, v); chk("R2 ctl readback", v, 16'h0F72);
      wr(3'd0, 16'h0004);
      wr(3'd2, 16'd3);
      wr(3'd0, 16'h0063);
      idle(2);
      rd(3'd4, v); chk("R2 stored-only bits", v, 16'd2);

      // R3 R4 sweep over prescale, modulus and elapsed cycles
      for (int p = 0; p < 4; p++) begin
         for (int li = 0; li < 4; li++) begin
            for (int mi = 0; mi < 6; mi++) begin
               int l, d, m, k;
               l = (li == 3) ? 5 : li + 1;
               d = 2 << p;
               case (mi)
                  0: m = 0;
                  1: m = d - 1;
                  2: m = d;
                  3: m = d * l - 1;
                  4: m = d * l;
                  default: m = d * l + d + 1;
               endcase
               k = m / d;
               wr(3'd0, 16'h0004);
               wr(3'd2, 16'(l));
               wr(3'd0, 16'h0003 | 16'(p << 8));
               idle(m);
               rd(3'd4, v);
               chk("R3 R4 sweep count", v, 16'(l - (k % l)));
            end
         end
      end

      // R3 largest prescale: first tick after 65536 cycles
      wr(3'd0, 16'h0004);
      wr(3'd2, 16'd3);
      wr(3'd0, 16'h0F03);
      idle(65535);
      rd(3'd4, v); chk("R3 max prescale before tick", v, 16'd3);
      rd(3'd4, v); chk("R3 max prescale after tick", v, 16'd2);

      // R8 light write keeps count, heavy write reloads
      wr(3'd0, 16'h0004);
      wr(3'd2, 16'd5);
      wr(3'd0, 16'h020B);
      idle(10);
      wr(3'd0, 16'h0203);
      rd(3'd4, v); chk("R8 light write undisturbed", v, 16'd4);
      wr(3'd0, 16'h0303);
      rd(3'd4, v); chk("R8 heavy write reload", v, 16'd5);

      // R6 R7 flag and interrupt
      wr(3'd0, 16'h0004);
      wr(3'd2, 16'd2);
      wr(3'd0, 16'h000B);
      idle(3);
      chk("R6 irq before wrap", {15'd0, irq_o}, 16'd0);
      idle(1);
      chk("R6 irq after wrap", {15'd0, irq_o}, 16'd1);
      wr(3'd0, 16'h0008);
      chk("R7 write zero keeps flag", {15'd0, irq_o}, 16'd1);
      wr(3'd0, 16'h0000);
      chk("R6 irq masked by enable", {15'd0, irq_o}, 16'd0);
      rd(3'd0, v); chk("R7 flag still pending", v, 16'h0004);
      wr(3'd0, 16'h000C);
      rd(3'd0, v); chk("R7 w1c clears flag", v, 16'h0008);
      chk("R6 irq low after clear", {15'd0, irq_o}, 16'd0);

      // R5 free-running reload with overwrite load while running
      wr(3'd0, 16'h0004);
      wr(3'd0, 16'h0011);
      wr(3'd2, 16'd3);
      idle(7);
      rd(3'd4, v); chk("R5 free-run wrap to FFFF", v, 16'hFFFE);
      rd(3'd0, v); chk("R6 flag after free-run wrap", v, 16'h0015);

      // R9 modulus writes
      wr(3'd0, 16'h0010);
      rd(3'd0, v); chk("R9 flag before mod write", v, 16'h0014);
      wr(3'd2, 16'h0123);
      rd(3'd0, v); chk("R9 mod write clears flag", v, 16'h0010);
      rd(3'd4, v); chk("R9 overwrite loads count", v, 16'h0123);
      wr(3'd0, 16'h0000);
      wr(3'd2, 16'h0040);
      rd(3'd4, v); chk("R9 no overwrite keeps count", v, 16'hFFFF);
      rd(3'd2, v); chk("R9 mod readback", v, 16'h0040);
      wr(3'd2, 16'd4);
      wr(3'd0, 16'h0003);
      wr(3'd2, 16'd2);
      idle(9);
      rd(3'd4, v); chk("R9 deferred modulus at reload", v, 16'd1);

      // R10 read-only count and unmapped offsets
      wr(3'd0, 16'h0004);
      wr(3'd2, 16'd7);
      wr(3'd0, 16'h0002);
      wr(3'd4, 16'h1234);
      rd(3'd4, v); chk("R10 count ignores write", v, 16'd7);
      rd(3'd6, v); chk("R10 unmapped reads zero", v, 16'h0000);
      rd(3'd1, v); chk("R10 odd offset reads zero", v, 16'h0000);
      wr(3'd6, 16'hFFFF);
      rd(3'd0, v); chk("R10 unmapped write ctl", v, 16'h0002);
      rd(3'd2, v); chk("R10 unmapped write mod", v, 16'd7);

      // R11 registered read data
      rd(3'd0, v);
      bus_addr = 3'd2;
      #1;
      chk("R11 read data lags address", bus_rdata, 16'h0002);
      @(negedge clk);
      chk("R11 read data after edge", bus_rdata, 16'd7);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule